// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It uses two levels of state. The first level is a bank of per-branch outcome histories, and a slice of the branch address picks one history. The second level is a table of 2-bit saturating counters. This table is shared by every branch and is addressed only by the history value. Two branches whose recent outcomes match therefore consult, and train, the same counter.

Two ports work independently in the same cycle. The lookup port takes a fetch address and returns a direction with no clock in between. The training port takes a resolved branch address and its real outcome, and changes both levels at the next rising edge. The block is fully synchronous and has a synchronous, active-high reset.

Top module: `lhp_predictor`

## Requirements
- R1: After reset, every history entry is zero and every counter holds weakly-not-taken (2'b01), so every address predicts not taken.
- R2: `look_taken` follows combinationally from `look_pc`. It is 1 exactly when the counter addressed by that slot's history holds 2'b10 (weakly taken) or 2'b11 (strongly taken). The encoding runs 00 strongly-not-taken, 01 weakly-not-taken, 10 weakly-taken, 11 strongly-taken.
- R3: The history slot is address bits [9:2]. Bits [1:0] and bits above 9 do not change the slot.
- R4: A taken outcome moves the trained counter one step toward 2'b11 and leaves it at 2'b11 once there.
- R5: A not-taken outcome moves the trained counter one step toward 2'b00 and leaves it at 2'b00 once there.
- R6: An update first trains the counter chosen by the slot's pre-update history. It then shifts the outcome (1 = taken) into bit 0 of that slot's 8-bit history and drops bit 7.
- R7: The counter table is indexed by history alone. A branch that was never trained predicts from the counter trained by any other branch with the same history.
- R8: When `train_valid` is low, no history and no counter changes.
- R9: A lookup in the same cycle as an update to the same entries returns the values from before that update.
- R10: Storage is 256 x 8 history bits plus 256 x 2 counter bits, 2560 bits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| look_pc | input | 32 | Address of the branch being predicted |
| look_taken | output | 1 | Predicted direction, 1 = taken |
| train_valid | input | 1 | Apply a training update this cycle |
| train_pc | input | 32 | Address of the resolved branch |
| train_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench trains one branch with repeated taken outcomes until its history saturates at all ones. It then keeps pushing that counter past 2'b11 and drives a second counter down past 2'b00. A design that wraps instead of saturating would flip its prediction at exactly those points.

Aliased addresses that differ only in bits [1:0] or above bit 9 must train the same history. A design that slices the wrong address bits would leave the original branch predicting taken.

A branch that was never trained is looked up after an unrelated branch has trained the shared zero-history counter. An index that mixes in the address would miss that counter. Invalid not-taken updates, and lookups made in the same cycle as an update, must leave the visible prediction at its pre-update value.

Finally, a repeating five-taken, two-not-taken pattern is run on two branches against an independent model. The final period must be predicted perfectly, which a wrong shift direction would break.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
package lhp_pkg;

    localparam int DEF_PC_W    = 32;
    localparam int DEF_IDX_LSB = 2;
    localparam int DEF_IDX_W   = 8;
    localparam int DEF_HIST_W  = 8;
    localparam int CTR_W       = 2;

    localparam int STORAGE_BITS = (1 << DEF_IDX_W) * DEF_HIST_W
                                + (1 << DEF_HIST_W) * CTR_W;

    typedef enum logic [CTR_W-1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    // one saturating training step
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            default:       nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return (cur == CTR_WEAK_T) || (cur == CTR_STRONG_T);
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
`timescale 1ns/1ps
module lhp_hist_table #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_slot,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [IDX_W-1:0]  rd_b_slot,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [HIST_W-1:0] wr_hist
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_SLOT = IDX_W'(e);
        logic [HIST_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_slot == MY_SLOT)) begin
                q <= wr_hist;
            end
        end
        assign hist_q[e] = q;
    end

    assign rd_a_hist = hist_q[rd_a_slot];
    assign rd_b_hist = hist_q[rd_b_slot];

endmodule

// File: rtl/lhp_pattern_table.sv
`timescale 1ns/1ps
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_a_idx,
    output ctr_e              rd_a_ctr,
    input  logic [HIST_W-1:0] rd_b_idx,
    output ctr_e              rd_b_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  ctr_e              wr_ctr
);
    localparam int ENTRIES = 1 << HIST_W;

    ctr_e tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_ctr;
        end
    end

    assign rd_a_ctr = tbl[rd_a_idx];
    assign rd_b_ctr = tbl[rd_b_idx];

endmodule

// File: rtl/lhp_trainer.sv
`timescale 1ns/1ps
module lhp_trainer
    import lhp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic [HIST_W-1:0] cur_hist,
    input  ctr_e              cur_ctr,
    input  logic              taken,
    output logic [HIST_W-1:0] nxt_hist,
    output ctr_e              nxt_ctr
);
    always_comb begin
        nxt_ctr  = ctr_step(cur_ctr, taken);
        nxt_hist = {cur_hist[HIST_W-2:0], taken};
    end
endmodule

// File: rtl/lhp_predictor.sv
`timescale 1ns/1ps
module lhp_predictor
    import lhp_pkg::*;
#(
    parameter int PC_W    = DEF_PC_W,
    parameter int IDX_LSB = DEF_IDX_LSB,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int HIST_W  = DEF_HIST_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_taken,
    input  logic            train_valid,
    input  logic [PC_W-1:0] train_pc,
    input  logic            train_taken
);
    localparam int IDX_HI = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0]  look_slot, upd_slot;
    logic [HIST_W-1:0] look_hist, upd_hist, new_hist;
    ctr_e              look_ctr, upd_ctr, new_ctr;

    assign look_slot = look_pc[IDX_HI:IDX_LSB];
    assign upd_slot  = train_pc[IDX_HI:IDX_LSB];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{look_pc[PC_W-1:IDX_HI+1], look_pc[IDX_LSB-1:0],
                              train_pc[PC_W-1:IDX_HI+1], train_pc[IDX_LSB-1:0]};

    lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .rd_a_slot (look_slot),
        .rd_a_hist (look_hist),
        .rd_b_slot (upd_slot),
        .rd_b_hist (upd_hist),
        .wr_en     (train_valid),
        .wr_slot   (upd_slot),
        .wr_hist   (new_hist)
    );

    lhp_pattern_table #(.HIST_W(HIST_W)) u_pat (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (look_hist),
        .rd_a_ctr (look_ctr),
        .rd_b_idx (upd_hist),
        .rd_b_ctr (upd_ctr),
        .wr_en    (train_valid),
        .wr_idx   (upd_hist),
        .wr_ctr   (new_ctr)
    );

    lhp_trainer #(.HIST_W(HIST_W)) u_train (
        .cur_hist (upd_hist),
        .cur_ctr  (upd_ctr),
        .taken    (train_taken),
        .nxt_hist (new_hist),
        .nxt_ctr  (new_ctr)
    );

    assign look_taken = ctr_says_taken(look_ctr);

endmodule

// File: rtl/lhp_checker.sv
`timescale 1ns/1ps
module lhp_checker
    import lhp_pkg::*;
#(
    parameter int PC_W    = DEF_PC_W,
    parameter int IDX_LSB = DEF_IDX_LSB,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int HIST_W  = DEF_HIST_W
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   look_pc,
    input logic              look_taken,
    input logic              train_valid,
    input logic [PC_W-1:0]   train_pc,
    input logic              train_taken,
    input logic [HIST_W-1:0] look_hist,
    input logic [HIST_W-1:0] upd_hist,
    input ctr_e              upd_ctr
);
    localparam int IDX_HI = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] c_look_slot, c_upd_slot;
    assign c_look_slot = look_pc[IDX_HI:IDX_LSB];
    assign c_upd_slot  = train_pc[IDX_HI:IDX_LSB];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!look_taken && upd_hist == '0 && upd_ctr == CTR_WEAK_NT));

    assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
        (train_valid && train_taken) |=>
            (!(train_valid && upd_hist == $past(upd_hist)) ||
             upd_ctr == (($past(upd_ctr) == CTR_STRONG_T) ? CTR_STRONG_T
                                                          : ctr_e'($past(upd_ctr) + 2'd1))));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
        (train_valid && !train_taken) |=>
            (!(train_valid && upd_hist == $past(upd_hist)) ||
             upd_ctr == (($past(upd_ctr) == CTR_STRONG_NT) ? CTR_STRONG_NT
                                                           : ctr_e'($past(upd_ctr) - 2'd1))));

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
        train_valid |=>
            (!(train_valid && c_upd_slot == $past(c_upd_slot)) ||
             upd_hist == {$past(upd_hist[HIST_W-2:0]), $past(train_taken)}));

    assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        !train_valid |=> (!$stable(train_pc) || ($stable(upd_hist) && $stable(upd_ctr))));

    assert_same_slot_read_R9: assert property (@(posedge clk) disable iff (rst)
        (train_valid && c_look_slot == c_upd_slot) |-> (look_hist == upd_hist));

endmodule

bind lhp_predictor lhp_checker #(
    .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .look_pc     (look_pc),
    .look_taken  (look_taken),
    .train_valid (train_valid),
    .train_pc    (train_pc),
    .train_taken (train_taken),
    .look_hist   (look_hist),
    .upd_hist    (upd_hist),
    .upd_ctr     (upd_ctr)
);

// File: tb/sim_lhp_predictor.sv
`timescale 1ns/1ps
module sim_lhp_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] look_pc = '0;
    logic        look_taken;
    logic        train_valid = 1'b0;
    logic [31:0] train_pc = '0;
    logic        train_taken = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lhp_predictor u0 (
        .clk         (clk),
        .rst         (rst),
        .look_pc     (look_pc),
        .look_taken  (look_taken),
        .train_valid (train_valid),
        .train_pc    (train_pc),
        .train_taken (train_taken)
    );

    // {outcome, expected prediction} for the saturating all-taken walk on one branch
    localparam logic [1:0] WALK [14] = '{
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b11, 2'b11, 2'b11, 2'b11, 2'b11
    };

    localparam logic [31:0] PC_A = 32'h0000_0124;
    localparam logic [31:0] PC_B = 32'h0000_0080;
    localparam logic [31:0] PC_C = 32'h0000_0040;
    localparam logic [31:0] PC_E = 32'h0000_00C0;
    localparam logic [31:0] PC_F = 32'h0000_0100;
    localparam logic [31:0] PC_P = 32'h0000_0200;
    localparam logic [31:0] PC_Q = 32'h0000_03FC;

    task automatic chk(input logic got, input logic exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        train_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one cycle at the falling edge, sample the prediction 1 ns later
    task automatic cyc(input logic [31:0] lpc, input logic v,
                       input logic [31:0] upc, input logic t);
        @(negedge clk);
        look_pc     = lpc;
        train_valid = v;
        train_pc    = upc;
        train_taken = t;
        #1;
    endtask

    logic [7:0] m_hist [256];
    int         m_ctr  [256];

    initial begin
        do_reset();

        // R1: every address starts not taken
        foreach (WALK[i]) begin
            cyc(32'h0000_1000 * i + 32'(i * 4), 1'b0, '0, 1'b0);
            chk(look_taken, 1'b0, "R1 reset prediction");
        end

        // R10: storage sizing
        n_vec++;
        if (lhp_pkg::STORAGE_BITS != 256 * 8 + 256 * 2) begin
            n_bad++;
            $display("FAIL R10: got %0d expected %0d", lhp_pkg::STORAGE_BITS, 2560);
        end

        // R4 R6 R9: table walk, lookup and update to the same branch each cycle
        foreach (WALK[i]) begin
            cyc(PC_A, 1'b1, PC_A, WALK[i][1]);
            chk(look_taken, WALK[i][0], $sformatf("R4/R6/R9 walk step %0d", i));
        end
        cyc(PC_A, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R4 saturated at strongly taken");

        // R3: aliases of PC_A share its slot
        cyc(PC_A | 32'h3, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R3 low bits ignored");
        cyc(PC_A + 32'h0000_0400, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R3 high bits ignored");
        cyc(PC_A, 1'b1, PC_A + 32'h8000_0400, 1'b0);
        cyc(PC_A, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b0, "R3 alias trained the same history");
        cyc(PC_A | 32'h1, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b0, "R3 alias low bits after training");
        cyc(PC_A + 32'h4, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R3 neighbour slot keeps zero history");

        // R7 R8 R5 R9: shared counter at history zero
        do_reset();
        cyc(PC_B, 1'b1, PC_C, 1'b1);
        cyc(PC_B, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R7 untrained branch shares counter");
        for (int k = 0; k < 4; k++) begin
            cyc(PC_B, 1'b0, PC_B, 1'b0);
            chk(look_taken, 1'b1, "R8 invalid update ignored");
        end
        cyc(PC_B, 1'b1, PC_B, 1'b0);
        chk(look_taken, 1'b1, "R9 same-cycle lookup sees old counter");
        cyc(PC_B, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b0, "R5 step down to weakly not taken");
        cyc(PC_B, 1'b1, PC_B, 1'b0);
        cyc(PC_B, 1'b1, PC_B, 1'b0);
        cyc(PC_B, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b0, "R5 strongly not taken");
        cyc(PC_B, 1'b1, PC_B, 1'b1);
        cyc(PC_E, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b0, "R5 saturated at strongly not taken");
        cyc(PC_E, 1'b1, PC_E, 1'b1);
        cyc(PC_F, 1'b0, '0, 1'b0);
        chk(look_taken, 1'b1, "R4 one step up to weakly taken");

        // R2 R6: repeating T,T,T,T,T,N,N against an independent model
        do_reset();
        for (int i = 0; i < 256; i++) begin
            m_hist[i] = '0;
            m_ctr[i]  = 1;
        end
        for (int p = 0; p < 40; p++) begin
            for (int k = 0; k < 7; k++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] upc, lpc;
                    logic        t, v, exp_p;
                    logic [7:0]  sl, h;
                    upc = s ? PC_Q : PC_P;
                    t   = (k < 5);
                    v   = !(p == 5 && k == 2);
                    lpc = (p >= 38 || ((p + k + s) % 3) != 0) ? upc : (s ? PC_P : PC_Q);
                    cyc(lpc, v, upc, t);
                    exp_p = (m_ctr[m_hist[lpc[9:2]]] >= 2);
                    chk(look_taken, exp_p, "R2 model prediction");
                    if (p == 39) chk(look_taken, t, "R6 steady-state pattern learned");
                    if (v) begin
                        sl = upc[9:2];
                        h  = m_hist[sl];
                        if (t) m_ctr[h] = (m_ctr[h] == 3) ? 3 : m_ctr[h] + 1;
                        else   m_ctr[h] = (m_ctr[h] == 0) ? 0 : m_ctr[h] - 1;
                        m_hist[sl] = {h[6:0], t};
                    end
                end
            end
        end

        cyc(PC_P, 1'b0, '0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule